// File: doc/BRIEF.md
# Link Synchronization Acquisition Monitor

This block watches the stream of decoded code groups on a receive path and reports whether the link is synchronized. Each parallel clock it receives one qualifier for the current code group. The qualifier says whether a group is present, whether the group is a synchronization group, and whether it was flagged as erroneous. It drives a single level output, `syncStatus`, that the rest of the receiver uses to gate its data.

Two runtime thresholds govern the machine. The first is the number of synchronization groups needed to declare sync. The second is the number of back-to-back erroneous groups that declares loss. The thresholds are captured only while the link is out of sync. A link that is up therefore keeps the rules it was acquired under, even if software rewrites the threshold inputs. Once sync is lost, the acquisition count starts again from zero and must be met in full.

Top module: `link_sync_monitor`

## Requirements
- R1: During and after reset `syncStatus` is 0, both counters are zero, and both captured thresholds hold the all-ones value until they are reloaded.
- R2: While `syncStatus` is 0, each group with `grpValid`=1, `syncGrp`=1 and `errGrp`=0 adds one to the acquisition count. When the count reaches the captured acquisition threshold, `syncStatus` reads 1 in the cycle after the clock edge that sampled the qualifying group.
- R3: While `syncStatus` is 0, a valid group with `errGrp`=1 clears the acquisition count to zero.
- R4: Once high, `syncStatus` stays high on every cycle until the loss condition of R5 is met.
- R5: While `syncStatus` is 1, `syncStatus` reads 0 in the cycle after the edge that samples the Nth consecutive valid group with `errGrp`=1, where N is the captured loss threshold.
- R6: While `syncStatus` is 1, any valid group with `errGrp`=0 resets the consecutive-error count to zero.
- R7: On loss of sync both counters clear, so the full acquisition threshold must be met again.
- R8: `acqThresh` and `lossThresh` are captured on every clock edge at which `syncStatus` is 0, and are held unchanged while it is 1. A captured value of 0 acts as 1.
- R9: When `syncGrp` and `errGrp` are both 1 on a valid group, the group counts as erroneous only.
- R10: A cycle with `grpValid`=0 changes neither counter nor `syncStatus`, whatever `syncGrp` and `errGrp` carry. A valid group with both flags 0 while out of sync leaves the acquisition count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grpValid | input | 1 | A code group is present this cycle |
| syncGrp | input | 1 | The group is a synchronization group |
| errGrp | input | 1 | The group is erroneous |
| acqThresh | input | CNT_W | Sync groups needed to acquire (0 acts as 1) |
| lossThresh | input | CNT_W | Consecutive errors that drop sync (0 acts as 1) |
| syncStatus | output | 1 | Level: link synchronized |

## Verification
The assertions take for granted that the three group qualifiers are known (not X) on every clock edge after reset. They also assume any threshold change is seen through the capture registers only. Under those assumptions a rising status always follows a clean sync group, and a falling status always follows an erroneous one. The stimulus drives every input away from the active edge and always as a defined 0 or 1. It keeps the random thresholds between 1 and 6 so that both transitions occur often, and it reaches the value 0 only in a directed case.

// File: rtl/link_sync_pkg.sv
package link_sync_pkg;

  typedef enum logic {
    ST_LOST = 1'b0,
    ST_SYNC = 1'b1
  } syncState_t;

  typedef struct packed {
    logic acqInc;
    logic acqClr;
    logic errInc;
    logic errClr;
    logic thrLoad;
  } ctrlStrobes_t;

endpackage

// File: rtl/link_sync_dp.sv
module link_sync_dp
  import link_sync_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strb,
  input  logic [CNT_W-1:0] acqThresh,
  input  logic [CNT_W-1:0] lossThresh,
  output logic             acqHit,
  output logic             lossHit,
  output logic [CNT_W-1:0] acqCnt,
  output logic [CNT_W-1:0] errCnt,
  output logic [CNT_W-1:0] lossEff
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] acqShadow;
  logic [CNT_W-1:0] lossShadow;
  logic [CNT_W-1:0] acqEff;
  logic [CNT_W:0]   acqNext;
  logic [CNT_W:0]   errNext;

  // Capture the programmed thresholds only while the link is out of sync
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acqShadow  <= ALL_ONES;
      lossShadow <= ALL_ONES;
    end else if (strb.thrLoad) begin
      acqShadow  <= acqThresh;
      lossShadow <= lossThresh;
    end
  end

  // A programmed zero behaves as a threshold of one
  assign acqEff  = (acqShadow  == '0) ? ONE : acqShadow;
  assign lossEff = (lossShadow == '0) ? ONE : lossShadow;

  assign acqNext = {1'b0, acqCnt} + 1'b1;
  assign errNext = {1'b0, errCnt} + 1'b1;
  assign acqHit  = (acqNext >= {1'b0, acqEff});
  assign lossHit = (errNext >= {1'b0, lossEff});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acqCnt <= '0;
    end else if (strb.acqClr) begin
      acqCnt <= '0;
    end else if (strb.acqInc) begin
      acqCnt <= acqNext[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      errCnt <= '0;
    end else if (strb.errClr) begin
      errCnt <= '0;
    end else if (strb.errInc) begin
      errCnt <= errNext[CNT_W-1:0];
    end
  end

  // R8
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.thrLoad |=> ($stable(acqShadow) && $stable(lossShadow)));

  // R3
  acq_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.acqInc |-> (acqCnt != ALL_ONES));

endmodule

// File: rtl/link_sync_ctrl.sv
module link_sync_ctrl
  import link_sync_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         grpValid,
  input  logic         syncGrp,
  input  logic         errGrp,
  input  logic         acqHit,
  input  logic         lossHit,
  output ctrlStrobes_t strb,
  output logic         syncStatus
);

  syncState_t state, stateNext;
  logic       goodSync;
  logic       badGrp;
  logic       goodGrp;

  // An error flag always wins over the sync flag
  assign badGrp   = grpValid && errGrp;
  assign goodSync = grpValid && syncGrp && !errGrp;
  assign goodGrp  = grpValid && !errGrp;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_LOST: begin
        strb.thrLoad = 1'b1;
        if (badGrp) begin
          strb.acqClr = 1'b1;
        end else if (goodSync) begin
          if (acqHit) begin
            stateNext   = ST_SYNC;
            strb.acqClr = 1'b1;
            strb.errClr = 1'b1;
          end else begin
            strb.acqInc = 1'b1;
          end
        end
      end
      ST_SYNC: begin
        if (badGrp) begin
          if (lossHit) begin
            stateNext   = ST_LOST;
            strb.acqClr = 1'b1;
            strb.errClr = 1'b1;
          end else begin
            strb.errInc = 1'b1;
          end
        end else if (goodGrp) begin
          strb.errClr = 1'b1;
        end
      end
      default: stateNext = ST_LOST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_LOST;
    end else begin
      state <= stateNext;
    end
  end

  assign syncStatus = (state == ST_SYNC);

  // R2
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(syncStatus) |-> $past(grpValid && syncGrp && !errGrp));

  // R5
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(syncStatus) |-> $past(grpValid && errGrp));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grpValid |=> $stable(syncStatus));

endmodule

// File: rtl/link_sync_monitor.sv
module link_sync_monitor
  import link_sync_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grpValid,
  input  logic             syncGrp,
  input  logic             errGrp,
  input  logic [CNT_W-1:0] acqThresh,
  input  logic [CNT_W-1:0] lossThresh,
  output logic             syncStatus
);

  ctrlStrobes_t     strb;
  logic             acqHit;
  logic             lossHit;
  logic [CNT_W-1:0] acqCnt;
  logic [CNT_W-1:0] errCnt;
  logic [CNT_W-1:0] lossEff;

  link_sync_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .grpValid  (grpValid),
    .syncGrp   (syncGrp),
    .errGrp    (errGrp),
    .acqHit    (acqHit),
    .lossHit   (lossHit),
    .strb      (strb),
    .syncStatus(syncStatus)
  );

  link_sync_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .acqThresh (acqThresh),
    .lossThresh(lossThresh),
    .acqHit    (acqHit),
    .lossHit   (lossHit),
    .acqCnt    (acqCnt),
    .errCnt    (errCnt),
    .lossEff   (lossEff)
  );

  // R6
  good_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (syncStatus && grpValid && !errGrp) |=> (errCnt == '0));

  // R3
  err_clears_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!syncStatus && grpValid && errGrp) |=> (acqCnt == '0));

  // R5
  err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syncStatus |-> (errCnt < lossEff));

  // R7
  loss_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(syncStatus) |-> (acqCnt == '0 && errCnt == '0));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!syncStatus && acqCnt == '0 && errCnt == '0));

endmodule

// File: tb/link_sync_monitor_bench.sv
module link_sync_monitor_bench;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             grpValid = 1'b0;
  logic             syncGrp = 1'b0;
  logic             errGrp = 1'b0;
  logic [CNT_W-1:0] acqThresh = 8'd3;
  logic [CNT_W-1:0] lossThresh = 8'd2;
  logic             syncStatus;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state, derived from the requirements
  bit mSync;
  int mAcq, mErr, mAS, mLS;

  always #2.5 clk = ~clk;

  link_sync_monitor #(.CNT_W(CNT_W)) u_link_sync_monitor (
    .clk(clk), .rst_n(rst_n), .grpValid(grpValid), .syncGrp(syncGrp),
    .errGrp(errGrp), .acqThresh(acqThresh), .lossThresh(lossThresh),
    .syncStatus(syncStatus)
  );

  function automatic int effThr(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic modelReset();
    mSync = 1'b0; mAcq = 0; mErr = 0; mAS = 255; mLS = 255;
  endtask

  // One clock edge of the reference, using the inputs sampled at that edge
  task automatic modelEdge(bit v, bit s, bit e, int aT, int lT);
    if (!mSync) begin
      if (v && e) mAcq = 0;
      else if (v && s) begin
        if (mAcq + 1 >= effThr(mAS)) begin
          mSync = 1'b1; mAcq = 0; mErr = 0;
        end else mAcq++;
      end
      mAS = aT; mLS = lT;
    end else if (v) begin
      if (e) begin
        if (mErr + 1 >= effThr(mLS)) begin
          mSync = 1'b0; mAcq = 0; mErr = 0;
        end else mErr++;
      end else mErr = 0;
    end
  endtask

  task automatic check(string tag, bit actual, bit expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s syncStatus actual=%0b expected=%0b at %0t", tag, actual, expected, $time);
    end
  endtask

  // Entered at a falling edge; drives, lets one rising edge pass, samples at the next falling edge
  task automatic step(string tag, bit v, bit s, bit e);
    grpValid = v; syncGrp = s; errGrp = e;
    @(posedge clk);
    modelEdge(v, s, e, int'(acqThresh), int'(lossThresh));
    @(negedge clk);
    check(tag, syncStatus, mSync);
  endtask

  initial begin
    modelReset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", syncStatus, 1'b0);
    rst_n = 1'b1;
    // let thresholds 3/2 be captured
    step("R1", 0, 0, 0);
    step("R10", 1, 0, 0);
    // R2: three sync groups to acquire
    step("R2", 1, 1, 0);
    step("R2", 1, 1, 0);
    check("R2 not yet", syncStatus, 1'b0);
    step("R2", 1, 1, 0);
    check("R2 acquired", syncStatus, 1'b1);
    // R10: invalid cycles carrying error flags are ignored
    step("R10", 0, 0, 1);
    step("R10", 0, 1, 1);
    step("R10", 0, 0, 1);
    check("R10 ignored", syncStatus, 1'b1);
    // R6: a good group breaks the error run
    step("R6", 1, 0, 1);
    step("R6", 1, 0, 0);
    step("R6", 1, 0, 1);
    check("R4 held", syncStatus, 1'b1);
    // R5: two consecutive errors drop sync
    step("R5", 1, 0, 1);
    check("R5 lost", syncStatus, 1'b0);
    // R3 and R9: errors (also combined with sync) reset acquisition
    step("R7", 1, 1, 0);
    step("R7", 1, 1, 0);
    step("R9", 1, 1, 1);
    step("R3", 1, 1, 0);
    step("R3", 1, 1, 0);
    check("R3 restart", syncStatus, 1'b0);
    step("R3", 1, 1, 0);
    check("R3 acquired", syncStatus, 1'b1);
    // R8: threshold raised while in sync has no effect
    lossThresh = 8'd5;
    step("R8", 1, 0, 1);
    step("R8", 1, 0, 1);
    check("R8 held threshold", syncStatus, 1'b0);
    // R8: zero behaves as one
    acqThresh = 8'd0; lossThresh = 8'd0;
    step("R8", 1, 0, 0);
    step("R8", 1, 1, 0);
    check("R8 zero acq", syncStatus, 1'b1);
    step("R8", 1, 0, 1);
    check("R8 zero loss", syncStatus, 1'b0);
    // R7: full count needed again after loss
    acqThresh = 8'd4; lossThresh = 8'd3;
    step("R7", 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R7", 1, 1, 0);
    check("R7 partial", syncStatus, 1'b0);
    step("R7", 1, 1, 0);
    check("R7 reacquired", syncStatus, 1'b1);
    // Random phase
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      bit v, s, e;
      if (i % 60 == 0) begin
        acqThresh  = 8'($urandom_range(1, 6));
        lossThresh = 8'($urandom_range(1, 6));
      end
      v = ($urandom_range(0, 9) < 8);
      s = ($urandom_range(0, 9) < 6);
      e = ($urandom_range(0, 9) < 3);
      step("R4", v, s, e);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule